// File: doc/BRIEF.md
# Clock Mode Transition Sequencer

This block steps a clock generator from the mode it is in to a mode that is asked for. The generator has eight modes, encoded 0 to 7: FLL on internal reference (0), FLL on external reference (1), FLL bypassed on internal reference (2), FLL bypassed on external reference (3), low-power on internal reference (4), low-power on external reference (5), PLL bypassed (6) and PLL engaged (7). A jump between two distant modes is not allowed directly. The block therefore looks up the next legal hop in a fixed 8x8 routing function. For each hop it drives the generator's control lines and then waits for the status lines that confirm them. Only after that does it commit the hop as the new current mode.

Each status wait is bounded by a programmable limit. If the limit expires, the request is aborted with an error and the last committed mode is kept. A separate recovery request backs out of the low-power and PLL modes in a fixed order. It then settles in mode 0 with the smallest FLL multiplier, so the chip can start from a known state after a warm restart.

Top module: `clk_mode_seq`

## Requirements
- R1: After reset: current mode 0, busy/done/err low, clock select 0, internal reference selected, low-power 0, PLL select 0, external reference enable 0, FLL factor code = INT_FACTOR.
- R2: Each hop goes to route(current, target), given per current mode as the hop for targets 0..7. Mode 0 and mode 1: 0,1,2,3,2,3,3,3. Mode 2: 0,1,2,3,4,3,3,3. Mode 3: 0,1,2,3,2,5,6,6. Mode 4: 2,2,2,2,4,2,2,2. Mode 5: 3,3,3,3,3,5,6,6. Mode 6: 3,3,3,3,3,5,6,7. Mode 7: 6,6,6,6,6,6,6,7. The current mode changes once per committed hop.
- R3: A request with a 4-bit target of 8 or more gives a one-cycle err in the following cycle. Busy stays low and the current mode is unchanged.
- R4: A request whose target equals the current mode still runs one hop, including its status waits.
- R5: Clock status codes are 0 = FLL, 1 = internal, 2 = external, 3 = PLL. The hops for modes 0, 1 and 2 set the following and wait for the status listed:
  - Mode 0: factor INT, select 0, internal reference, low-power 0; waits for internal-reference status, then clock status 0.
  - Mode 1: external reference enabled, factor EXT, select 0, external reference; waits for clock status 0.
  - Mode 2: factor INT, low-power 0, select 1, internal reference; waits for clock status 1, then internal-reference status.
- R6: The hops for modes 3, 6 and 7 set the following and wait for the status listed:
  - Mode 3: external enable, factor EXT, low-power 0, select 2, external reference; waits for clock status 2, then clears PLL select.
  - Mode 6: low-power 0, select 2; waits for clock status 2, sets PLL select, waits for the PLL-source status, then waits for lock.
  - Mode 7: select 0; waits for clock status 3.
- R7: The hops for modes 4 and 5 set low-power and clear PLL select, with no status wait. Low-power and PLL select are never high together.
- R8: A wait that stays unmet for tmoLimit+1 consecutive cycles aborts the request with a one-cycle err. The current mode stays at the last committed hop.
- R9: Busy rises the cycle after an accepted request and stays high until done or err. Done is a one-cycle pulse, with busy low, once the committed mode equals the target.
- R10: Recovery proceeds in this order:
  - Clears low-power if it is set.
  - If PLL select is set with select 0, moves to select 2 and waits for clock status 2.
  - Clears PLL select and waits for the PLL-source status to drop.
  - Sets factor code SAFE_FACTOR, select 0 and internal reference, and waits as in the mode 0 hop.
  - Commits mode 0 and pulses done.
- R11: Requests and recovery requests that arrive while busy are ignored. Recovery wins over a plain request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Mode change request strobe |
| reqMode | input | 4 | Requested target mode |
| recoverReq | input | 1 | Recovery request strobe |
| tmoLimit | input | TMO_W | Status wait limit |
| stClk | input | 2 | Clock status (0 FLL, 1 internal, 2 external, 3 PLL) |
| stIref | input | 1 | FLL reference is internal |
| stPllSrc | input | 1 | PLL is the selected loop source |
| stLock | input | 1 | PLL lock |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle error pulse |
| curMode | output | 3 | Last committed mode |
| clkSel | output | 2 | Output clock select |
| irefSel | output | 1 | Internal reference for FLL |
| lowPwr | output | 1 | Low-power (loops off) |
| pllSel | output | 1 | PLL selected as loop |
| extRefEn | output | 1 | External reference enable |
| fllFactor | output | FAC_W | FLL multiplier code |

## Verification
The assertions watch, on every cycle, the invariants that hold whatever the routing:
- done and err never overlap, and done comes with busy low;
- the current mode moves only while a sequence runs, and an error leaves it where it was;
- the wait counter is idle outside a sequence;
- low-power never coexists with PLL select;
- a low-power hop commits without waiting.

The route taken, the settings each destination mode leaves behind, the exact cycle on which a timeout fires, and the ignored mid-flight request can only be shown by the bench's scenarios. The bench shows them by driving a status model with variable delay and the ability to freeze it.

// File: rtl/clk_mode_seq_pkg.sv
package clk_mode_seq_pkg;

  localparam int NUM_MODES = 8;
  localparam int MODE_W    = 3;
  localparam int REQ_W     = 4;

  typedef enum logic [MODE_W-1:0] {
    FLL_INT = 3'd0,
    FLL_EXT = 3'd1,
    BYP_INT = 3'd2,
    BYP_EXT = 3'd3,
    LP_INT  = 3'd4,
    LP_EXT  = 3'd5,
    PLL_BYP = 3'd6,
    PLL_ENG = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    FAC_INT  = 2'd0,
    FAC_EXT  = 2'd1,
    FAC_SAFE = 2'd2
  } factor_sel_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic        start;
    logic        loadTgt;
    mode_e       tgtVal;
    logic        loadHop;
    mode_e       hopVal;
    logic        commit;
    logic        finishOk;
    logic        finishErr;
    logic        waiting;
    logic        setFactor;
    factor_sel_e factorVal;
    logic        setClk;
    logic [1:0]  clkVal;
    logic        setIref;
    logic        irefVal;
    logic        setLp;
    logic        lpVal;
    logic        setPll;
    logic        pllVal;
    logic        setExt;
    logic        extVal;
  } strobe_t;

  // next legal hop; each row packs the hop for targets 7..0, 3 bits each
  function automatic mode_e routeHop(input mode_e cur, input mode_e tgt);
    logic [3*NUM_MODES-1:0] row;
    mode_e hop;
    case (cur)
      FLL_INT, FLL_EXT: row = {3'd3, 3'd3, 3'd3, 3'd2, 3'd3, 3'd2, 3'd1, 3'd0};
      BYP_INT:          row = {3'd3, 3'd3, 3'd3, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
      BYP_EXT:          row = {3'd6, 3'd6, 3'd5, 3'd2, 3'd3, 3'd2, 3'd1, 3'd0};
      LP_INT:           row = {3'd2, 3'd2, 3'd2, 3'd4, 3'd2, 3'd2, 3'd2, 3'd2};
      LP_EXT:           row = {3'd6, 3'd6, 3'd5, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3};
      PLL_BYP:          row = {3'd7, 3'd6, 3'd5, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3};
      default:          row = {3'd7, 3'd6, 3'd6, 3'd6, 3'd6, 3'd6, 3'd6, 3'd6};
    endcase
    hop = FLL_INT;
    for (int t = 0; t < NUM_MODES; t++) begin
      if (t == int'(tgt)) hop = mode_e'(row[MODE_W*t +: MODE_W]);
    end
    return hop;
  endfunction

endpackage

// File: rtl/clk_mode_seq_ctrl.sv
module clk_mode_seq_ctrl
  import clk_mode_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [REQ_W-1:0] reqMode,
  input  logic             recoverReq,
  input  mode_e            curMode,
  input  mode_e            tgtMode,
  input  mode_e            hopMode,
  input  logic             ctlLowPwr,
  input  logic             ctlPllSel,
  input  logic [1:0]       ctlClkSel,
  input  logic [1:0]       stClk,
  input  logic             stIref,
  input  logic             stPllSrc,
  input  logic             stLock,
  input  logic             tmoHit,
  output strobe_t          stb
);

  typedef enum logic [4:0] {
    S_IDLE, S_ROUTE, S_COMMIT,
    S_FI_SET, S_FI_WREF, S_FI_WCLK,
    S_FE_SET, S_FE_WCLK,
    S_BI_SET, S_BI_WCLK, S_BI_WREF,
    S_BE_SET, S_BE_WCLK, S_BE_PLLOFF,
    S_LP_SET,
    S_PB_SET, S_PB_WCLK, S_PB_PLLON, S_PB_WSRC, S_PB_WLOCK,
    S_PE_SET, S_PE_WCLK,
    S_RC_LP, S_RC_CLK, S_RC_WCLK, S_RC_PLLOFF, S_RC_WSRC,
    S_RC_FEI, S_RC_WREF, S_RC_WCLK0
  } seq_state_e;

  seq_state_e state, nxt, waitNext;
  logic       isWait, waitCond;
  mode_e      hop;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb      = '0;
    nxt      = state;
    isWait   = 1'b0;
    waitCond = 1'b0;
    waitNext = S_IDLE;
    hop      = routeHop(curMode, tgtMode);
    case (state)
      S_IDLE: begin
        if (recoverReq) begin
          stb.start   = 1'b1;
          stb.loadTgt = 1'b1;
          stb.tgtVal  = FLL_INT;
          nxt         = S_RC_LP;
        end else if (reqValid) begin
          if (int'(reqMode) >= NUM_MODES) begin
            stb.finishErr = 1'b1;
          end else begin
            stb.start   = 1'b1;
            stb.loadTgt = 1'b1;
            stb.tgtVal  = mode_e'(reqMode[MODE_W-1:0]);
            nxt         = S_ROUTE;
          end
        end
      end
      S_ROUTE: begin
        stb.loadHop = 1'b1;
        stb.hopVal  = hop;
        case (hop)
          FLL_INT: nxt = S_FI_SET;
          FLL_EXT: nxt = S_FE_SET;
          BYP_INT: nxt = S_BI_SET;
          BYP_EXT: nxt = S_BE_SET;
          LP_INT, LP_EXT: nxt = S_LP_SET;
          PLL_BYP: nxt = S_PB_SET;
          default: nxt = S_PE_SET;
        endcase
      end
      S_COMMIT: begin
        stb.commit = 1'b1;
        if (hopMode == tgtMode) begin
          stb.finishOk = 1'b1;
          nxt          = S_IDLE;
        end else begin
          nxt = S_ROUTE;
        end
      end
      // internal-reference FLL hop
      S_FI_SET: begin
        stb.setFactor = 1'b1; stb.factorVal = FAC_INT;
        stb.setClk = 1'b1;  stb.clkVal = 2'd0;
        stb.setIref = 1'b1; stb.irefVal = 1'b1;
        stb.setLp = 1'b1;   stb.lpVal = 1'b0;
        nxt = S_FI_WREF;
      end
      S_FI_WREF: begin isWait = 1'b1; waitCond = stIref;         waitNext = S_FI_WCLK; end
      S_FI_WCLK: begin isWait = 1'b1; waitCond = (stClk == 2'd0); waitNext = S_COMMIT;  end
      // external-reference FLL hop
      S_FE_SET: begin
        stb.setExt = 1'b1; stb.extVal = 1'b1;
        stb.setFactor = 1'b1; stb.factorVal = FAC_EXT;
        stb.setClk = 1'b1;  stb.clkVal = 2'd0;
        stb.setIref = 1'b1; stb.irefVal = 1'b0;
        nxt = S_FE_WCLK;
      end
      S_FE_WCLK: begin isWait = 1'b1; waitCond = (stClk == 2'd0); waitNext = S_COMMIT; end
      // bypassed, internal reference
      S_BI_SET: begin
        stb.setFactor = 1'b1; stb.factorVal = FAC_INT;
        stb.setLp = 1'b1;   stb.lpVal = 1'b0;
        stb.setClk = 1'b1;  stb.clkVal = 2'd1;
        stb.setIref = 1'b1; stb.irefVal = 1'b1;
        nxt = S_BI_WCLK;
      end
      S_BI_WCLK: begin isWait = 1'b1; waitCond = (stClk == 2'd1); waitNext = S_BI_WREF; end
      S_BI_WREF: begin isWait = 1'b1; waitCond = stIref;         waitNext = S_COMMIT;  end
      // bypassed, external reference
      S_BE_SET: begin
        stb.setExt = 1'b1; stb.extVal = 1'b1;
        stb.setFactor = 1'b1; stb.factorVal = FAC_EXT;
        stb.setLp = 1'b1;   stb.lpVal = 1'b0;
        stb.setClk = 1'b1;  stb.clkVal = 2'd2;
        stb.setIref = 1'b1; stb.irefVal = 1'b0;
        nxt = S_BE_WCLK;
      end
      S_BE_WCLK: begin isWait = 1'b1; waitCond = (stClk == 2'd2); waitNext = S_BE_PLLOFF; end
      S_BE_PLLOFF: begin
        stb.setPll = 1'b1; stb.pllVal = 1'b0;
        nxt = S_COMMIT;
      end
      // low-power hops never wait
      S_LP_SET: begin
        stb.setLp = 1'b1;  stb.lpVal = 1'b1;
        stb.setPll = 1'b1; stb.pllVal = 1'b0;
        nxt = S_COMMIT;
      end
      // PLL bypassed
      S_PB_SET: begin
        stb.setLp = 1'b1;  stb.lpVal = 1'b0;
        stb.setClk = 1'b1; stb.clkVal = 2'd2;
        nxt = S_PB_WCLK;
      end
      S_PB_WCLK: begin isWait = 1'b1; waitCond = (stClk == 2'd2); waitNext = S_PB_PLLON; end
      S_PB_PLLON: begin
        stb.setPll = 1'b1; stb.pllVal = 1'b1;
        nxt = S_PB_WSRC;
      end
      S_PB_WSRC:  begin isWait = 1'b1; waitCond = stPllSrc; waitNext = S_PB_WLOCK; end
      S_PB_WLOCK: begin isWait = 1'b1; waitCond = stLock;   waitNext = S_COMMIT;   end
      // PLL engaged
      S_PE_SET: begin
        stb.setClk = 1'b1; stb.clkVal = 2'd0;
        nxt = S_PE_WCLK;
      end
      S_PE_WCLK: begin isWait = 1'b1; waitCond = (stClk == 2'd3); waitNext = S_COMMIT; end
      // recovery
      S_RC_LP: begin
        if (ctlLowPwr) begin stb.setLp = 1'b1; stb.lpVal = 1'b0; end
        nxt = S_RC_CLK;
      end
      S_RC_CLK: begin
        if (ctlPllSel && ctlClkSel == 2'd0) begin
          stb.setClk = 1'b1; stb.clkVal = 2'd2;
          nxt = S_RC_WCLK;
        end else begin
          nxt = S_RC_PLLOFF;
        end
      end
      S_RC_WCLK: begin isWait = 1'b1; waitCond = (stClk == 2'd2); waitNext = S_RC_PLLOFF; end
      S_RC_PLLOFF: begin
        if (ctlPllSel) begin
          stb.setPll = 1'b1; stb.pllVal = 1'b0;
          nxt = S_RC_WSRC;
        end else begin
          nxt = S_RC_FEI;
        end
      end
      S_RC_WSRC: begin isWait = 1'b1; waitCond = !stPllSrc; waitNext = S_RC_FEI; end
      S_RC_FEI: begin
        stb.setFactor = 1'b1; stb.factorVal = FAC_SAFE;
        stb.setClk = 1'b1;  stb.clkVal = 2'd0;
        stb.setIref = 1'b1; stb.irefVal = 1'b1;
        stb.loadHop = 1'b1; stb.hopVal = FLL_INT;
        nxt = S_RC_WREF;
      end
      S_RC_WREF:  begin isWait = 1'b1; waitCond = stIref;         waitNext = S_RC_WCLK0; end
      S_RC_WCLK0: begin isWait = 1'b1; waitCond = (stClk == 2'd0); waitNext = S_COMMIT;   end
      default: nxt = S_IDLE;
    endcase

    if (isWait) begin
      if (waitCond) begin
        nxt = waitNext;
      end else if (tmoHit) begin
        stb.finishErr = 1'b1;
        nxt           = S_IDLE;
      end else begin
        stb.waiting = 1'b1;
      end
    end
  end

  // R7
  lp_hop_no_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LP_SET) |=> (state == S_COMMIT));

  // R10
  rc_pll_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RC_FEI) |-> (!ctlPllSel && !ctlLowPwr));

  // R9
  idle_not_waiting_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !stb.waiting);

endmodule

// File: rtl/clk_mode_seq_dp.sv
module clk_mode_seq_dp
  import clk_mode_seq_pkg::*;
#(
  parameter int               TMO_W       = 8,
  parameter int               FAC_W       = 2,
  parameter logic [FAC_W-1:0] INT_FACTOR  = 1,
  parameter logic [FAC_W-1:0] EXT_FACTOR  = 2,
  parameter logic [FAC_W-1:0] SAFE_FACTOR = 0
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [TMO_W-1:0] tmoLimit,
  output mode_e            curMode,
  output mode_e            tgtMode,
  output mode_e            hopMode,
  output logic             tmoHit,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [1:0]       clkSel,
  output logic             irefSel,
  output logic             lowPwr,
  output logic             pllSel,
  output logic             extRefEn,
  output logic [FAC_W-1:0] fllFactor
);

  logic [TMO_W-1:0] tmoCnt;
  logic [FAC_W-1:0] factorNext;

  always_comb begin
    case (stb.factorVal)
      FAC_EXT:  factorNext = EXT_FACTOR;
      FAC_SAFE: factorNext = SAFE_FACTOR;
      default:  factorNext = INT_FACTOR;
    endcase
  end

  assign tmoHit = (tmoCnt >= tmoLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode   <= FLL_INT;
      tgtMode   <= FLL_INT;
      hopMode   <= FLL_INT;
      tmoCnt    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      clkSel    <= 2'd0;
      irefSel   <= 1'b1;
      lowPwr    <= 1'b0;
      pllSel    <= 1'b0;
      extRefEn  <= 1'b0;
      fllFactor <= INT_FACTOR;
    end else begin
      if (stb.loadTgt) tgtMode <= stb.tgtVal;
      if (stb.loadHop) hopMode <= stb.hopVal;
      if (stb.commit)  curMode <= hopMode;
      tmoCnt <= stb.waiting ? tmoCnt + 1'b1 : '0;
      if (stb.start) busy <= 1'b1;
      else if (stb.finishOk || stb.finishErr) busy <= 1'b0;
      done <= stb.finishOk;
      err  <= stb.finishErr;
      if (stb.setClk)    clkSel    <= stb.clkVal;
      if (stb.setIref)   irefSel   <= stb.irefVal;
      if (stb.setLp)     lowPwr    <= stb.lpVal;
      if (stb.setPll)    pllSel    <= stb.pllVal;
      if (stb.setExt)    extRefEn  <= stb.extVal;
      if (stb.setFactor) fllFactor <= factorNext;
    end
  end

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !err));

  // R9
  mode_moves_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curMode) |-> $past(busy));

  // R3
  err_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (curMode == $past(curMode)));

  // R8
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (tmoCnt == '0));

  // R7
  lp_pll_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowPwr |-> !pllSel);

endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
  import clk_mode_seq_pkg::*;
#(
  parameter int               TMO_W       = 8,
  parameter int               FAC_W       = 2,
  parameter logic [FAC_W-1:0] INT_FACTOR  = 1,
  parameter logic [FAC_W-1:0] EXT_FACTOR  = 2,
  parameter logic [FAC_W-1:0] SAFE_FACTOR = 0
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [3:0]       reqMode,
  input  logic             recoverReq,
  input  logic [TMO_W-1:0] tmoLimit,
  input  logic [1:0]       stClk,
  input  logic             stIref,
  input  logic             stPllSrc,
  input  logic             stLock,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       curMode,
  output logic [1:0]       clkSel,
  output logic             irefSel,
  output logic             lowPwr,
  output logic             pllSel,
  output logic             extRefEn,
  output logic [FAC_W-1:0] fllFactor
);

  strobe_t stb;
  mode_e   curM, tgtM, hopM;
  logic    tmoHit;

  clk_mode_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqMode    (reqMode),
    .recoverReq (recoverReq),
    .curMode    (curM),
    .tgtMode    (tgtM),
    .hopMode    (hopM),
    .ctlLowPwr  (lowPwr),
    .ctlPllSel  (pllSel),
    .ctlClkSel  (clkSel),
    .stClk      (stClk),
    .stIref     (stIref),
    .stPllSrc   (stPllSrc),
    .stLock     (stLock),
    .tmoHit     (tmoHit),
    .stb        (stb)
  );

  clk_mode_seq_dp #(
    .TMO_W       (TMO_W),
    .FAC_W       (FAC_W),
    .INT_FACTOR  (INT_FACTOR),
    .EXT_FACTOR  (EXT_FACTOR),
    .SAFE_FACTOR (SAFE_FACTOR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .tmoLimit  (tmoLimit),
    .curMode   (curM),
    .tgtMode   (tgtM),
    .hopMode   (hopM),
    .tmoHit    (tmoHit),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .clkSel    (clkSel),
    .irefSel   (irefSel),
    .lowPwr    (lowPwr),
    .pllSel    (pllSel),
    .extRefEn  (extRefEn),
    .fllFactor (fllFactor)
  );

  assign curMode = curM;

endmodule

// File: tb/clk_mode_seq_bench.sv
module clk_mode_seq_bench;

  localparam logic [1:0] F_INT  = 2'd1;
  localparam logic [1:0] F_EXT  = 2'd2;
  localparam logic [1:0] F_SAFE = 2'd0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [3:0] reqMode = '0;
  logic       recoverReq = 1'b0;
  logic [7:0] tmoLimit = 8'd20;
  logic [1:0] stClk;
  logic       stIref, stPllSrc, stLock;
  logic       busy, done, err, irefSel, lowPwr, pllSel, extRefEn;
  logic [2:0] curMode;
  logic [1:0] clkSel, fllFactor;

  always #10 clk = ~clk;

  clk_mode_seq #(.TMO_W(8), .FAC_W(2), .INT_FACTOR(F_INT), .EXT_FACTOR(F_EXT),
                 .SAFE_FACTOR(F_SAFE)) u_clk_mode_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .recoverReq(recoverReq), .tmoLimit(tmoLimit), .stClk(stClk), .stIref(stIref),
    .stPllSrc(stPllSrc), .stLock(stLock), .busy(busy), .done(done), .err(err),
    .curMode(curMode), .clkSel(clkSel), .irefSel(irefSel), .lowPwr(lowPwr),
    .pllSel(pllSel), .extRefEn(extRefEn), .fllFactor(fllFactor));

  // generator status model: delayed echo of the controls
  int         lat = 1;
  bit         hold = 1'b0;
  bit         stuckIref = 1'b0;
  logic [4:0] des;
  logic [4:0] pipe [0:4];
  logic [4:0] sv;

  always_comb des = {((clkSel == 2'd0) && pllSel) ? 2'd3 : clkSel, irefSel, pllSel, pllSel};

  always_ff @(posedge clk) begin
    if (!hold) begin
      pipe[0] <= des;
      for (int i = 4; i > 0; i--) pipe[i] <= pipe[i-1];
    end
  end

  always_comb begin
    sv       = (lat == 0) ? des : pipe[lat-1];
    stClk    = sv[4:3];
    stIref   = stuckIref ? 1'b0 : sv[2];
    stPllSrc = sv[1];
    stLock   = pipe[lat][0];
  end

  int nChk = 0, nBad = 0;
  bit finished = 1'b0;
  int expMode = 0;
  bit recovered = 1'b0;
  int obsPath [8];
  int obsLen = 0;
  int prevMode = 0;

  always @(posedge clk) begin
    if (int'(curMode) != prevMode) begin
      if (obsLen < 8) obsPath[obsLen] = int'(curMode);
      obsLen++;
    end
    prevMode = int'(curMode);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int hopOf(input int c, input int t);
    int r [8];
    case (c)
      0, 1: r = '{0, 1, 2, 3, 2, 3, 3, 3};
      2:    r = '{0, 1, 2, 3, 4, 3, 3, 3};
      3:    r = '{0, 1, 2, 3, 2, 5, 6, 6};
      4:    r = '{2, 2, 2, 2, 4, 2, 2, 2};
      5:    r = '{3, 3, 3, 3, 3, 5, 6, 6};
      6:    r = '{3, 3, 3, 3, 3, 5, 6, 7};
      default: r = '{6, 6, 6, 6, 6, 6, 6, 7};
    endcase
    return r[t];
  endfunction

  // {clkSel, irefSel, lowPwr, pllSel, fllFactor}
  function automatic logic [6:0] expCtl(input int m, input bit rec);
    case (m)
      0: return {2'd0, 1'b1, 1'b0, 1'b0, rec ? F_SAFE : F_INT};
      1: return {2'd0, 1'b0, 1'b0, 1'b0, F_EXT};
      2: return {2'd1, 1'b1, 1'b0, 1'b0, F_INT};
      3: return {2'd2, 1'b0, 1'b0, 1'b0, F_EXT};
      4: return {2'd1, 1'b1, 1'b1, 1'b0, F_INT};
      5: return {2'd2, 1'b0, 1'b1, 1'b0, F_EXT};
      6: return {2'd2, 1'b0, 1'b0, 1'b1, F_EXT};
      default: return {2'd0, 1'b0, 1'b0, 1'b1, F_EXT};
    endcase
  endfunction

  function automatic logic [6:0] actCtl();
    return {clkSel, irefSel, lowPwr, pllSel, fllFactor};
  endfunction

  task automatic runReq(input int m, input int inject);
    int n;
    int c;
    int eLen;
    int ePath [8];
    string rq;
    @(negedge clk);
    obsLen = 0;
    reqValid = 1'b1;
    reqMode = m[3:0];
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    if (m >= 8) begin
      check(err == 1'b1 && busy == 1'b0, "R3", "invalid target err", int'(err), 1);
      check(int'(curMode) == expMode, "R3", "mode kept on invalid", int'(curMode), expMode);
      @(negedge clk);
      check(err == 1'b0, "R3", "err one cycle", int'(err), 0);
      return;
    end
    check(busy == 1'b1, "R9", "busy after request", int'(busy), 1);
    while (!done && !err && n < 600) begin
      @(negedge clk);
      n++;
      if (n == 3 && inject >= 0) begin
        reqValid = 1'b1;
        reqMode = inject[3:0];
      end else begin
        reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R9", "done reached", int'(done), 1);
    if (!done) return;
    check(int'(curMode) == m, "R2", "final mode", int'(curMode), m);
    if (inject >= 0)
      check(int'(curMode) == m, "R11", "mid-flight request ignored", int'(curMode), m);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9", "done single cycle", int'(done), 0);
    c = expMode;
    eLen = 0;
    do begin
      int h;
      h = hopOf(c, m);
      if (h != c) begin ePath[eLen] = h; eLen++; end
      c = h;
    end while (c != m);
    check(obsLen == eLen, "R2", "hop count", obsLen, eLen);
    for (int i = 0; i < eLen && i < obsLen; i++)
      check(obsPath[i] == ePath[i], "R2", "hop mode", obsPath[i], ePath[i]);
    rq = (m == 4 || m == 5) ? "R7" : ((m <= 2) ? "R5" : "R6");
    check(actCtl() == expCtl(m, 1'b0), rq, "controls in mode", int'(actCtl()),
          int'(expCtl(m, 1'b0)));
    expMode = m;
    recovered = 1'b0;
  endtask

  task automatic runRec();
    int n;
    @(negedge clk);
    recoverReq = 1'b1;
    @(negedge clk);
    recoverReq = 1'b0;
    n = 1;
    check(busy == 1'b1, "R9", "busy after recovery", int'(busy), 1);
    while (!done && !err && n < 600) begin @(negedge clk); n++; end
    check(done == 1'b1, "R10", "recovery done", int'(done), 1);
    check(int'(curMode) == 0, "R10", "recovery mode", int'(curMode), 0);
    check(actCtl() == expCtl(0, 1'b1), "R10", "recovery controls", int'(actCtl()),
          int'(expCtl(0, 1'b1)));
    @(negedge clk);
    expMode = 0;
    recovered = 1'b1;
  endtask

  // request expected to end in a timeout error
  task automatic runErr(input int m, input int expN, input string rq);
    int n;
    @(negedge clk);
    reqValid = 1'b1;
    reqMode = m[3:0];
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    while (!done && !err && n < 600) begin @(negedge clk); n++; end
    check(err == 1'b1 && done == 1'b0, rq, "error raised", int'(err), 1);
    if (expN > 0) check(n == expN, rq, "timeout cycle", n, expN);
    check(int'(curMode) == expMode, rq, "last committed mode kept", int'(curMode), expMode);
    @(negedge clk);
    check(err == 1'b0 && busy == 1'b0, rq, "err pulse ends", int'(err), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(curMode == 3'd0 && !busy && !done && !err, "R1", "reset status", int'(curMode), 0);
    check(actCtl() == expCtl(0, 1'b0) && !extRefEn, "R1", "reset controls",
          int'(actCtl()), int'(expCtl(0, 1'b0)));

    // R4 same target re-runs its hop (proved by a stuck wait)
    tmoLimit = 8'd5;
    stuckIref = 1'b1;
    runErr(0, 0, "R4");
    stuckIref = 1'b0;
    runReq(0, -1);

    // directed long paths
    lat = 2;
    runReq(7, -1);
    runReq(4, -1);
    runReq(5, -1);
    runRec();
    runReq(6, -1);
    runRec();

    // R3 invalid targets
    runReq(8, -1);
    runReq(15, -1);

    // R11 request while busy
    runReq(7, 1);
    runReq(0, -1);

    // R8 exact timeout with frozen status
    lat = 1;
    tmoLimit = 8'd5;
    @(negedge clk);
    hold = 1'b1;
    runErr(3, 9, "R8");
    hold = 1'b0;
    runReq(0, -1);

    // R8 slow status inside the limit passes
    lat = 3;
    tmoLimit = 8'd3;
    runReq(7, -1);
    tmoLimit = 8'd20;

    // R7 low-power hop with frozen status still completes
    lat = 1;
    runReq(2, -1);
    @(negedge clk);
    hold = 1'b1;
    runReq(4, -1);
    hold = 1'b0;
    runRec();

    // constrained random
    for (int k = 0; k < 80; k++) begin
      int r;
      lat = int'($urandom % 4);
      r = int'($urandom % 10);
      if (($urandom % 8) == 0) runRec();
      else runReq(r, -1);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule